// File: doc/BRIEF.md
# Serial DDS Tuning and Control Register File

This block receives 16-bit control words over a three-wire serial slave link (serial clock, active-low frame select, serial data) and keeps the tuning and control state of a direct digital synthesis core. It holds two 32-bit frequency tuning words, four 12-bit phase offsets, the frequency and phase selection fields, and the synchronisation, select-source and power control bits. All of these leave the block as parallel outputs to the synthesis core.

Each word carries a 4-bit command, a 4-bit register address and one data byte. Tuning registers are loaded in two steps. A "hold" command parks one byte in a shared holding register. A later "load" command writes that held byte, together with its own data byte, into one 16-bit half of a frequency word or into a whole phase word. The serial inputs are oversampled by the system clock, so the serial clock has to be several system clocks slower.

Top module: `dds_ctrl_regfile`

## Requirements
- R1: A word is bits 15:12 command, 11:8 address and 7:0 data, shifted MSB first. One bit is taken on each falling serial-clock edge while frame select is low. The word is accepted when frame select rises after exactly 16 such edges, and takes effect a few system clocks later.
- R2: A frame with fewer or more than 16 falling edges changes no state.
- R3: Command 0x2 at an even address below 0x8 writes {held byte, data byte} into frequency word addr[2]. Address bit 1 set selects bits 31:16; clear selects bits 15:0.
- R4: Command 0x0 at an even address of 0x8 or above writes {held byte bits 3:0, data byte} into phase word addr[2:1]. Held bits 7:4 are dropped.
- R5: A frequency load at an odd address or an address of 0x8 or above, and a phase load at an odd address or an address below 0x8, change no register.
- R6: Command 0x6 sets the frequency select from bit 11 and the phase select from bits 10:9.
- R7: Commands 0x8 to 0xB set sync from bit 13 and select-source from bit 12. With select-source set, the fsel_o and psel_o outputs follow the serial fields. With it clear, they follow the pin inputs.
- R8: Commands 0xC to 0xF set sleep from bit 13, core reset from bit 12 and clear from bit 11.
- R9: Commands 0x4, 0x5 and 0x7 change no state.
- R10: After reset, sleep, core reset and clear are 1. Every tuning word is 0, and the select fields, sync and select-source are 0.
- R11: Commands 0x3 and 0x1 only load the shared holding byte; no output changes. A load reuses the most recent held byte, even when no new hold came before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, idles high |
| fsync_n_i | input | 1 | Active-low frame select |
| sdata_i | input | 1 | Serial data |
| pin_fsel_i | input | 1 | Frequency select from a pin |
| pin_psel_i | input | 2 | Phase select from pins |
| freq_o | output | 64 | Frequency words, word 0 in the low 32 bits |
| phase_o | output | 48 | Phase words, word 0 in the low 12 bits |
| fsel_o | output | 1 | Active frequency select |
| psel_o | output | 2 | Active phase select |
| sync_o | output | 1 | Sync control bit |
| selsrc_o | output | 1 | Select-source bit (1 = serial fields) |
| sleep_o | output | 1 | Sleep control |
| core_rst_o | output | 1 | Core reset control |
| clr_o | output | 1 | Clear control |

## Verification
The bench goes after frame length. It sends a 9-edge frame and a 17-edge frame; a receiver that latched on the 16th edge or counted without a limit would apply a power command from those frames. It sends loads at odd and out-of-class addresses: a decoder that ignored address bits 3 or 0 would overwrite a frequency or phase word. A load with no hold before it must reuse the old held byte, and a design that cleared the holding byte after each load would write zeros instead. It also exercises the select-source switch and the unused command codes; getting either wrong shows up as select outputs tracking the wrong source, or as stray state changes.

// File: rtl/dds_ctl_pkg.sv
package dds_ctl_pkg;
  localparam int WORD_W = 16;

  localparam logic [3:0] OP_PH_LOAD = 4'h0;
  localparam logic [3:0] OP_PH_HOLD = 4'h1;
  localparam logic [3:0] OP_FR_LOAD = 4'h2;
  localparam logic [3:0] OP_FR_HOLD = 4'h3;
  localparam logic [3:0] OP_SELECT  = 4'h6;

  typedef struct packed {
    logic [3:0] op;
    logic [3:0] addr;
    logic [7:0] data;
  } ctl_word_t;

  typedef struct packed {
    logic       fsel;
    logic [1:0] psel;
    logic       sync;
    logic       src_serial;
    logic       sleep;
    logic       core_rst;
    logic       clr;
  } ctl_bits_t;
endpackage

// File: rtl/dds_ser_rx.sv
module dds_ser_rx #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              fsync_n_i,
  input  logic              sdata_i,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

  logic [SYNC_STAGES:0]   sclk_q, cs_q;
  logic [SYNC_STAGES-1:0] sd_q;
  logic [WORD_W-1:0]      shift_q, shift_d, word_q, word_d;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic                   vld_q, vld_d;
  logic                   sclk_fall, cs_low, cs_rise, shift_en;

  // edge detection on the synchronised copies
  assign sclk_fall = sclk_q[SYNC_STAGES] & ~sclk_q[SYNC_STAGES-1];
  assign cs_low    = ~cs_q[SYNC_STAGES-1];
  assign cs_rise   = cs_q[SYNC_STAGES-1] & ~cs_q[SYNC_STAGES];
  assign shift_en  = cs_low & sclk_fall;

  always_comb begin
    shift_d = {shift_q[WORD_W-2:0], sd_q[SYNC_STAGES-1]};
    cnt_d   = cnt_q;
    word_d  = word_q;
    vld_d   = 1'b0;
    if (cs_rise && cnt_q == CNT_FULL) begin
      vld_d  = 1'b1;
      word_d = shift_q;
    end
    if (!cs_low) begin
      cnt_d = '0;
    end else if (sclk_fall && cnt_q != CNT_OVER) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= '1;
      cs_q    <= '1;
      sd_q    <= '0;
      shift_q <= '0;
      cnt_q   <= '0;
      word_q  <= '0;
      vld_q   <= 1'b0;
    end else begin
      sclk_q <= {sclk_q[SYNC_STAGES-1:0], sclk_i};
      cs_q   <= {cs_q[SYNC_STAGES-1:0], fsync_n_i};
      sd_q   <= {sd_q[SYNC_STAGES-2:0], sdata_i};
      cnt_q  <= cnt_d;
      vld_q  <= vld_d;
      if (shift_en) shift_q <= shift_d;
      if (vld_d)    word_q  <= word_d;
    end
  end

  assign word_vld_o = vld_q;
  assign word_o     = word_q;
endmodule

// File: rtl/dds_cmd_dec.sv
module dds_cmd_dec
  import dds_ctl_pkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 12,
  parameter int N_FREQ  = 2,
  parameter int N_PHASE = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        word_vld_i,
  input  logic [WORD_W-1:0]           word_i,
  output logic [N_FREQ*FREQ_W-1:0]    freq_o,
  output logic [N_PHASE*PHASE_W-1:0]  phase_o,
  output ctl_bits_t                   ctl_o
);
  localparam int FHALF = FREQ_W / 2;
  localparam int PH_HI = PHASE_W - 8;
  localparam int FI_W  = (N_FREQ  > 1) ? $clog2(N_FREQ)  : 1;
  localparam int PI_W  = (N_PHASE > 1) ? $clog2(N_PHASE) : 1;

  logic [FREQ_W-1:0]  freq_q  [N_FREQ];
  logic [FREQ_W-1:0]  freq_d  [N_FREQ];
  logic [PHASE_W-1:0] phase_q [N_PHASE];
  logic [PHASE_W-1:0] phase_d [N_PHASE];
  logic [7:0]         hold_q, hold_d;
  ctl_bits_t          ctl_q, ctl_d;
  ctl_word_t          w;
  logic [FI_W-1:0]    fidx;
  logic [PI_W-1:0]    pidx;

  assign w    = ctl_word_t'(word_i);
  assign fidx = FI_W'(w.addr[2]);
  assign pidx = PI_W'(w.addr[2:1]);

  always_comb begin
    freq_d  = freq_q;
    phase_d = phase_q;
    hold_d  = hold_q;
    ctl_d   = ctl_q;
    casez (w.op)
      OP_FR_HOLD, OP_PH_HOLD: hold_d = w.data;
      OP_FR_LOAD: begin
        if (!w.addr[3] && !w.addr[0]) begin
          if (w.addr[1]) freq_d[fidx][FREQ_W-1:FHALF] = {hold_q, w.data};
          else           freq_d[fidx][FHALF-1:0]      = {hold_q, w.data};
        end
      end
      OP_PH_LOAD: begin
        if (w.addr[3] && !w.addr[0])
          phase_d[pidx] = {hold_q[PH_HI-1:0], w.data};
      end
      OP_SELECT: begin
        ctl_d.fsel = w.addr[3];
        ctl_d.psel = w.addr[2:1];
      end
      4'b10??: begin
        ctl_d.sync       = w.op[1];
        ctl_d.src_serial = w.op[0];
      end
      4'b11??: begin
        ctl_d.sleep    = w.op[1];
        ctl_d.core_rst = w.op[0];
        ctl_d.clr      = w.addr[3];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_FREQ; i++)  freq_q[i]  <= '0;
      for (int i = 0; i < N_PHASE; i++) phase_q[i] <= '0;
      hold_q <= '0;
      ctl_q  <= '{fsel: 1'b0, psel: 2'b00, sync: 1'b0, src_serial: 1'b0,
                  sleep: 1'b1, core_rst: 1'b1, clr: 1'b1};
    end else if (word_vld_i) begin
      freq_q  <= freq_d;
      phase_q <= phase_d;
      hold_q  <= hold_d;
      ctl_q   <= ctl_d;
    end
  end

  for (genvar g = 0; g < N_FREQ; g++) begin : g_freq
    assign freq_o[g*FREQ_W +: FREQ_W] = freq_q[g];
  end
  for (genvar g = 0; g < N_PHASE; g++) begin : g_phase
    assign phase_o[g*PHASE_W +: PHASE_W] = phase_q[g];
  end
  assign ctl_o = ctl_q;
endmodule

// File: rtl/dds_sel_src.sv
module dds_sel_src (
  input  logic       src_serial_i,
  input  logic       reg_fsel_i,
  input  logic [1:0] reg_psel_i,
  input  logic       pin_fsel_i,
  input  logic [1:0] pin_psel_i,
  output logic       fsel_o,
  output logic [1:0] psel_o
);
  always_comb begin
    if (src_serial_i) begin
      fsel_o = reg_fsel_i;
      psel_o = reg_psel_i;
    end else begin
      fsel_o = pin_fsel_i;
      psel_o = pin_psel_i;
    end
  end
endmodule

// File: rtl/dds_ctrl_regfile.sv
module dds_ctrl_regfile
  import dds_ctl_pkg::*;
#(
  parameter int FREQ_W      = 32,
  parameter int PHASE_W     = 12,
  parameter int N_FREQ      = 2,
  parameter int N_PHASE     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sclk_i,
  input  logic                       fsync_n_i,
  input  logic                       sdata_i,
  input  logic                       pin_fsel_i,
  input  logic [1:0]                 pin_psel_i,
  output logic [N_FREQ*FREQ_W-1:0]   freq_o,
  output logic [N_PHASE*PHASE_W-1:0] phase_o,
  output logic                       fsel_o,
  output logic [1:0]                 psel_o,
  output logic                       sync_o,
  output logic                       selsrc_o,
  output logic                       sleep_o,
  output logic                       core_rst_o,
  output logic                       clr_o
);
  logic              word_vld;
  logic [WORD_W-1:0] word;
  ctl_bits_t         ctl;
  logic              reg_fsel;
  logic [1:0]        reg_psel;

  dds_ser_rx #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) i_rx (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .fsync_n_i(fsync_n_i),
    .sdata_i(sdata_i), .word_vld_o(word_vld), .word_o(word)
  );

  dds_cmd_dec #(.FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .N_FREQ(N_FREQ),
                .N_PHASE(N_PHASE)) i_dec (
    .clk(clk), .rst_n(rst_n), .word_vld_i(word_vld), .word_i(word),
    .freq_o(freq_o), .phase_o(phase_o), .ctl_o(ctl)
  );

  assign reg_fsel = ctl.fsel;
  assign reg_psel = ctl.psel;

  dds_sel_src i_sel (
    .src_serial_i(ctl.src_serial), .reg_fsel_i(reg_fsel), .reg_psel_i(reg_psel),
    .pin_fsel_i(pin_fsel_i), .pin_psel_i(pin_psel_i),
    .fsel_o(fsel_o), .psel_o(psel_o)
  );

  assign sync_o     = ctl.sync;
  assign selsrc_o   = ctl.src_serial;
  assign sleep_o    = ctl.sleep;
  assign core_rst_o = ctl.core_rst;
  assign clr_o      = ctl.clr;
endmodule

// File: rtl/dds_ctrl_regfile_chk.sv
module dds_ctrl_regfile_chk #(
  parameter int FW = 64,
  parameter int PW = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          word_vld,
  input logic [15:0]   word,
  input logic [FW-1:0] freq,
  input logic [PW-1:0] phase,
  input logic          reg_fsel,
  input logic [1:0]    reg_psel,
  input logic          sync,
  input logic          src,
  input logic          sleep,
  input logic          core_rst,
  input logic          clr
);
  logic [6:0] ctl_v;
  assign ctl_v = {reg_fsel, reg_psel, sync, src, sleep, core_rst, clr};

  assert_reset_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sleep && core_rst && clr && !src && !sync &&
                      freq == '0 && phase == '0));

  assert_single_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld);

  assert_quiet_between_words_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |=> ($stable(freq) && $stable(phase) && $stable(ctl_v)));

  assert_bad_freq_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && word[15:12] == 4'h2 && (word[11] || word[8]))
      |=> ($stable(freq) && $stable(phase)));

  assert_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && word[15:12] == 4'h6)
      |=> (reg_fsel == $past(word[11]) && reg_psel == $past(word[10:9])));

  assert_sync_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && word[15:14] == 2'b10)
      |=> (sync == $past(word[13]) && src == $past(word[12])));

  assert_power_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && word[15:14] == 2'b11)
      |=> (sleep == $past(word[13]) && core_rst == $past(word[12]) &&
           clr == $past(word[11])));

  assert_unknown_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && (word[15:12] == 4'h4 || word[15:12] == 4'h5 || word[15:12] == 4'h7))
      |=> ($stable(freq) && $stable(phase) && $stable(ctl_v)));
endmodule

bind dds_ctrl_regfile dds_ctrl_regfile_chk #(
  .FW(N_FREQ*FREQ_W), .PW(N_PHASE*PHASE_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word(word),
  .freq(freq_o), .phase(phase_o), .reg_fsel(reg_fsel), .reg_psel(reg_psel),
  .sync(sync_o), .src(selsrc_o), .sleep(sleep_o), .core_rst(core_rst_o),
  .clr(clr_o)
);

// File: tb/test_dds_ctrl_regfile.sv
module test_dds_ctrl_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, sclk, fsync_n, sdata, pin_fsel;
  logic [1:0]  pin_psel;
  logic [63:0] freq;
  logic [47:0] phase;
  logic        fsel, sync, selsrc, sleep, core_rst, clr;
  logic [1:0]  psel;

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_ctrl_regfile i_dds_ctrl_regfile (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .fsync_n_i(fsync_n), .sdata_i(sdata),
    .pin_fsel_i(pin_fsel), .pin_psel_i(pin_psel), .freq_o(freq), .phase_o(phase),
    .fsel_o(fsel), .psel_o(psel), .sync_o(sync), .selsrc_o(selsrc),
    .sleep_o(sleep), .core_rst_o(core_rst), .clr_o(clr)
  );

  typedef struct {
    logic [63:0] f;
    logic [47:0] p;
    logic [7:0]  c;
    string       tag;
  } exp_t;

  exp_t q[$];
  event ev;
  int   checks = 0;
  int   errors = 0;

  // reference state built from the requirements
  logic [31:0] m_freq [2];
  logic [11:0] m_phase [4];
  logic [7:0]  m_hold;
  logic        m_fsel, m_sync, m_src, m_sleep, m_rst, m_clr;
  logic [1:0]  m_psel;

  task automatic model(input logic [15:0] w);
    logic [3:0] op, ad;
    op = w[15:12];
    ad = w[11:8];
    casez (op)
      4'h3, 4'h1: m_hold = w[7:0];
      4'h2: if (!ad[3] && !ad[0]) begin
              if (ad[1]) m_freq[ad[2]][31:16] = {m_hold, w[7:0]};
              else       m_freq[ad[2]][15:0]  = {m_hold, w[7:0]};
            end
      4'h0: if (ad[3] && !ad[0]) m_phase[ad[2:1]] = {m_hold[3:0], w[7:0]};
      4'h6: begin m_fsel = w[11]; m_psel = w[10:9]; end
      4'b10??: begin m_sync = w[13]; m_src = w[12]; end
      4'b11??: begin m_sleep = w[13]; m_rst = w[12]; m_clr = w[11]; end
      default: ;
    endcase
  endtask

  task automatic push(input string tag);
    exp_t it;
    it.f   = {m_freq[1], m_freq[0]};
    it.p   = {m_phase[3], m_phase[2], m_phase[1], m_phase[0]};
    it.c   = {m_src ? m_fsel : pin_fsel, m_src ? m_psel : pin_psel,
              m_sync, m_src, m_sleep, m_rst, m_clr};
    it.tag = tag;
    q.push_back(it);
    -> ev;
    repeat (10) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] bits, input int n);
    fsync_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = bits[i];
      repeat (3) @(negedge clk);
      sclk = 1'b0;
      repeat (3) @(negedge clk);
      sclk = 1'b1;
    end
    repeat (3) @(negedge clk);
    fsync_n = 1'b1;
  endtask

  task automatic send(input logic [15:0] w, input string tag);
    shift_bits({16'h0, w}, 16);
    model(w);
    push(tag);
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      exp_t it;
      @(ev);
      repeat (6) @(negedge clk);
      it = q.pop_front();
      chk(it.tag, "freq",  freq, it.f);
      chk(it.tag, "phase", {16'h0, phase}, {16'h0, it.p});
      chk(it.tag, "ctl",   {56'h0, fsel, psel, sync, selsrc, sleep, core_rst, clr},
                           {56'h0, it.c});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sclk = 1'b1; fsync_n = 1'b1; sdata = 1'b0;
    pin_fsel = 1'b1; pin_psel = 2'b11;
    m_freq[0] = '0; m_freq[1] = '0;
    for (int i = 0; i < 4; i++) m_phase[i] = '0;
    m_hold = '0; m_fsel = 0; m_psel = 0; m_sync = 0; m_src = 0;
    m_sleep = 1; m_rst = 1; m_clr = 1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    push("R10 reset");

    // frequency 0 = 12345678, frequency 1 = A5C30F1E
    send(16'h3312, "R11 hold");  send(16'h2234, "R3 high half");
    send(16'h3156, "R11 hold");  send(16'h2078, "R3/R1 low half");
    send(16'h37A5, "R11 hold");  send(16'h26C3, "R3 freq1 high");
    send(16'h350F, "R11 hold");  send(16'h241E, "R3 freq1 low");
    // phase words, upper nibble of held byte dropped
    send(16'h19F7, "R11 hold");  send(16'h0821, "R4 phase0");
    send(16'h1F0A, "R11 hold");  send(16'h0EBC, "R4 phase3");
    send(16'h1B05, "R11 hold");  send(16'h0A66, "R4 phase1");
    // out-of-class and odd addresses
    send(16'h3355, "R11 hold");  send(16'h2A11, "R5 freq addr>=8");
    send(16'h2311, "R5 freq odd");
    send(16'h0211, "R5 phase addr<8");
    send(16'h0911, "R5 phase odd");
    // load without a fresh hold reuses 0x55
    send(16'h2042, "R11 reuse held");
    // select source and select fields
    send(16'h6200, "R7 pins active");
    send(16'hB000, "R7 serial source");
    send(16'h6C00, "R6 select 1/2");
    send(16'h6000, "R6 select 0/0");
    send(16'h8000, "R7 back to pins");
    pin_fsel = 1'b0; pin_psel = 2'b01;
    push("R7 pin follow");
    // power bits
    send(16'hC000, "R8 all clear");
    send(16'hE800, "R8 sleep+clr");
    send(16'hD000, "R8 reset only");
    // unused codes
    send(16'h4FFF, "R9 op4");
    send(16'h5123, "R9 op5");
    send(16'h7E00, "R9 op7");
    // short and long frames
    shift_bits(32'h0000_01F0, 9);
    push("R2 short frame");
    shift_bits(32'h0001_F000, 17);
    push("R2 long frame");
    send(16'hF800, "R1 full frame after");
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule